// File: doc/BRIEF.md
# Queue-Mapped Register Operand Unit

This unit is the operand stage of the execute side of a decoupled processor. Each issued instruction carries two source specifiers and one destination specifier, each 5 bits wide. Codes 0 to 30 name ordinary architectural registers. Code 31 names no register. As a source it names the load-data queue, which the memory side fills ahead of use. As a destination it names the store-data queue, which the memory side drains.

A queue entry is consumed once. Naming the queue as a source pops its head, so the next such read sees the next value. When both sources name the queue, two consecutive entries are popped in one issue, and source A takes the older one. Issue is held back while the load queue has fewer entries than the instruction's queue sources need. It is also held back while an instruction that names the queue as its destination would find no free store slot. A store slot is reserved at issue and filled when the result is written back. Pops and reservations take effect only in the cycle an instruction actually issues.

Each queue keeps its occupancy in a three-state machine with the states Q_EMPTY, Q_PARTIAL and Q_FULL. The transitions are:
- Q_EMPTY goes to Q_PARTIAL on a push, or straight to Q_FULL when the depth is one.
- Q_PARTIAL goes to Q_EMPTY when its last entry leaves, and to Q_FULL when the last free slot is filled.
- Q_FULL goes to Q_PARTIAL or Q_EMPTY on any pop.

The empty and full flags are decoded from this state. The load queue's fill side and the store queue's drain side use ready/valid handshakes.

Top module: `qmr_operand_unit`

## Requirements
- R1: After reset both queues are empty, so `ld_in_ready` is 1 and `st_out_valid` is 0, and every register 0 to 30 reads as zero.
- R2: A write-back with `wb_dst` in 0 to 30 stores `wb_data`, and a later read of that code returns it.
- R3: When a source reads the same register code (0 to 30) that a write-back targets in the same cycle, the source returns the new `wb_data`.
- R4: An enabled source with code 31 returns the load-queue head and pops it on issue, so successive queue reads see values in arrival order.
- R5: When both enabled sources are code 31, source A returns the oldest entry, source B the next one, and both entries are popped in that one issue.
- R6: `iss_ready` is 0 while the number of enabled code-31 sources (0, 1 or 2) exceeds the load-queue occupancy, and no entry is popped in a cycle without issue.
- R7: An issue with `iss_dst_en` set and `iss_dst` equal to 31 reserves a store slot. `iss_ready` is 0 for such an instruction while the store occupancy plus the outstanding reservations is 8 or more.
- R8: A write-back to code 31 pushes `wb_data` into the store queue only while a reservation is outstanding, and consumes that reservation. The store queue presents its entries on `st_out_data` in push order, with `st_out_valid` high while it holds any entry.
- R9: The load queue holds 8 entries. `ld_in_ready` falls to 0 once 8 entries are held with no pop.
- R10: A source specifier of 31 whose enable is 0 pops nothing and does not stall issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_in_valid | input | 1 | Memory side offers a load datum |
| ld_in_ready | output | 1 | Load queue has room |
| ld_in_data | input | DATA_W | Load datum |
| iss_valid | input | 1 | An instruction requests issue |
| iss_ready | output | 1 | Issue may proceed this cycle (independent of iss_valid) |
| iss_src_a | input | 5 | Source A specifier |
| iss_src_a_en | input | 1 | Source A is used |
| iss_src_b | input | 5 | Source B specifier |
| iss_src_b_en | input | 1 | Source B is used |
| iss_dst | input | 5 | Destination specifier |
| iss_dst_en | input | 1 | Destination is used |
| opnd_a | output | DATA_W | Source A value, meaningful when issuing with A enabled |
| opnd_b | output | DATA_W | Source B value, meaningful when issuing with B enabled |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_dst | input | 5 | Write-back destination specifier |
| wb_data | input | DATA_W | Write-back value |
| st_out_valid | output | 1 | Store queue holds an entry |
| st_out_ready | input | 1 | Memory side takes the store head |
| st_out_data | output | DATA_W | Store queue head |

## Verification
Directed patterns separate the source combinations: register-only reads tell stored values from bypassed ones; a single queue source checks FIFO order; a double queue source checks which source receives the older entry; and a disabled code-31 source shows whether the head was wrongly consumed. Occupancy corners fill the load queue to its depth, starve a double pop with a single entry, and fill the store side with reservations until issue blocks. A reservation-free queue write shows whether unreserved data can leak out. A long random mix of issues, write-backs, fills and drains, compared every cycle against a bench model of the registers, queues and reservation count, exposes ordering errors and interlock errors that only show up under concurrent traffic.

// File: rtl/qmr_pkg.sv
package qmr_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SPEC_W = 5;
    localparam logic [SPEC_W-1:0] QUEUE_CODE = 5'd31;
    localparam int NUM_ARCH_REGS = 31;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_HEAD0 = 2'd1,
        SRC_HEAD1 = 2'd2
    } src_sel_e;
endpackage

// File: rtl/qmr_fifo.sv
module qmr_fifo
    import qmr_pkg::*;
#(
    parameter int W       = 32,
    parameter int DEPTH   = 8,
    parameter int MAX_POP = 2,
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic [1:0]    pop_n,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW+1:0] DEPTH_P = (PW + 2)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count_nx;
    q_state_e      state, state_nx;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [1:0] n);
        logic [PW+1:0] s;
        s = {2'b00, p} + {{PW{1'b0}}, n};
        if (s >= DEPTH_P) s = s - DEPTH_P;
        return s[PW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= adv(wr_ptr, 2'd1);
            rd_ptr <= adv(rd_ptr, pop_n);
            count  <= count_nx;
        end
    end

    always_comb count_nx = count + CW'(push) - CW'(pop_n);

    assign head0 = mem[rd_ptr];

    generate
        if (MAX_POP > 1) begin : g_dual_peek
            assign head1 = mem[adv(rd_ptr, 2'd1)];
        end else begin : g_single_peek
            assign head1 = '0;
        end
    endgenerate

    // occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY: begin
                if (push) state_nx = (count_nx == DEPTH_C) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (count_nx == '0)          state_nx = Q_EMPTY;
                else if (count_nx == DEPTH_C) state_nx = Q_FULL;
            end
            Q_FULL: begin
                if (pop_n != 2'd0) state_nx = (count_nx == '0) ? Q_EMPTY : Q_PARTIAL;
            end
            default: state_nx = Q_EMPTY;
        endcase
    end

    // output process
    always_comb begin
        empty = (state == Q_EMPTY);
        full  = (state == Q_FULL);
    end

    // R9: never written beyond its depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6: never popped below empty
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n != 2'd0) |-> (CW'(pop_n) <= count));

    // R1: flags decoded from state agree with the occupancy counter
    a_r1_flags_track_count: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (count == '0)) && (full == (count == DEPTH_C)));
endmodule

// File: rtl/qmr_regfile.sv
module qmr_regfile
    import qmr_pkg::*;
#(
    parameter int W     = 32,
    parameter int NREGS = NUM_ARCH_REGS,
    parameter int IDX_W = SPEC_W,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic [W-1:0]              wdata,
    input  logic [NRD-1:0][IDX_W-1:0] raddr,
    output logic [NRD-1:0][W-1:0]     rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] regs [NREGS];
    logic         wr_ok;

    assign wr_ok = we && (widx < IDX_W'(NREGS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (wr_ok) begin
            regs[widx] <= wdata;
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            always_comb begin
                if (wr_ok && widx == raddr[p])           rdata[p] = wdata;
                else if (raddr[p] < IDX_W'(NREGS))        rdata[p] = regs[raddr[p]];
                else                                      rdata[p] = '0;
            end
        end
    endgenerate

    // checker state for the storage property
    logic             last_we;
    logic [IDX_W-1:0] last_idx;
    logic [W-1:0]     last_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_we   <= 1'b0;
            last_idx  <= '0;
            last_data <= '0;
        end else begin
            last_we   <= wr_ok;
            last_idx  <= widx;
            last_data <= wdata;
        end
    end

    // R2: a write lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        last_we |-> (regs[last_idx] == last_data));
endmodule

// File: rtl/qmr_issue_ctl.sv
module qmr_issue_ctl
    import qmr_pkg::*;
#(
    parameter int LDQ_CW    = 4,
    parameter int STQ_CW    = 4,
    parameter int STQ_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [SPEC_W-1:0] src_a,
    input  logic              src_a_en,
    input  logic [SPEC_W-1:0] src_b,
    input  logic              src_b_en,
    input  logic [SPEC_W-1:0] dst,
    input  logic              dst_en,
    input  logic [LDQ_CW-1:0] ldq_count,
    input  logic [STQ_CW-1:0] stq_count,
    input  logic              wb_to_q,
    output logic              iss_ready,
    output logic [1:0]        pop_n,
    output src_sel_e          sel_a,
    output src_sel_e          sel_b,
    output logic              resv_avail
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [STQ_CW:0] STQ_LIMIT = (STQ_CW + 1)'(STQ_DEPTH);

    logic              a_q, b_q, d_q;
    logic [1:0]        need;
    logic              ld_short, st_short, fire;
    logic [STQ_CW-1:0] resv;
    logic [STQ_CW:0]   st_commit;

    always_comb begin
        a_q       = src_a_en && (src_a == QUEUE_CODE);
        b_q       = src_b_en && (src_b == QUEUE_CODE);
        d_q       = dst_en && (dst == QUEUE_CODE);
        need      = {1'b0, a_q} + {1'b0, b_q};
        ld_short  = (LDQ_CW'(need) > ldq_count);
        st_commit = {1'b0, stq_count} + {1'b0, resv};
        st_short  = d_q && (st_commit >= STQ_LIMIT);
        iss_ready = !ld_short && !st_short;
        fire      = iss_valid && iss_ready;
        pop_n     = fire ? need : 2'd0;
        sel_a     = a_q ? SRC_HEAD0 : SRC_REG;
        sel_b     = b_q ? (a_q ? SRC_HEAD1 : SRC_HEAD0) : SRC_REG;
    end

    assign resv_avail = (resv != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resv <= '0;
        else        resv <= resv + STQ_CW'(fire && d_q) - STQ_CW'(wb_to_q && resv_avail);
    end

    // R7: committed store slots never exceed the store queue depth
    a_r7_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, stq_count} + {1'b0, resv}) <= STQ_LIMIT);

    // R5: a double queue source always routes the older entry to A
    a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == SRC_HEAD1) |-> (sel_a == SRC_HEAD0));
endmodule

// File: rtl/qmr_operand_unit.sv
module qmr_operand_unit
    import qmr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LDQ_DEPTH = 8,
    parameter int STQ_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_in_valid,
    output logic              ld_in_ready,
    input  logic [DATA_W-1:0] ld_in_data,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [SPEC_W-1:0] iss_src_a,
    input  logic              iss_src_a_en,
    input  logic [SPEC_W-1:0] iss_src_b,
    input  logic              iss_src_b_en,
    input  logic [SPEC_W-1:0] iss_dst,
    input  logic              iss_dst_en,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    input  logic              wb_valid,
    input  logic [SPEC_W-1:0] wb_dst,
    input  logic [DATA_W-1:0] wb_data,
    output logic              st_out_valid,
    input  logic              st_out_ready,
    output logic [DATA_W-1:0] st_out_data
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LDQ_CW = $clog2(LDQ_DEPTH + 1);
    localparam int STQ_CW = $clog2(STQ_DEPTH + 1);

    logic [DATA_W-1:0] ldq_h0, ldq_h1, stq_h0, stq_h1;
    logic [LDQ_CW-1:0] ldq_cnt;
    logic [STQ_CW-1:0] stq_cnt;
    logic              ldq_empty, ldq_full, stq_empty, stq_full;
    logic              ld_push, st_push, st_pop, wb_to_q, resv_avail;
    logic [1:0]        ldq_pop_n;
    src_sel_e          sel_a, sel_b;

    logic [1:0][SPEC_W-1:0] rf_addr;
    logic [1:0][DATA_W-1:0] rf_data;

    assign ld_in_ready = !ldq_full;
    assign ld_push     = ld_in_valid && !ldq_full;
    assign wb_to_q     = wb_valid && (wb_dst == QUEUE_CODE);
    assign st_push     = wb_to_q && resv_avail;
    assign st_pop      = st_out_ready && !stq_empty;
    assign st_out_valid = !stq_empty;
    assign st_out_data  = stq_h0;

    qmr_issue_ctl #(
        .LDQ_CW(LDQ_CW), .STQ_CW(STQ_CW), .STQ_DEPTH(STQ_DEPTH)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .src_a(iss_src_a), .src_a_en(iss_src_a_en),
        .src_b(iss_src_b), .src_b_en(iss_src_b_en),
        .dst(iss_dst), .dst_en(iss_dst_en),
        .ldq_count(ldq_cnt), .stq_count(stq_cnt), .wb_to_q(wb_to_q),
        .iss_ready(iss_ready), .pop_n(ldq_pop_n),
        .sel_a(sel_a), .sel_b(sel_b), .resv_avail(resv_avail)
    );

    qmr_fifo #(.W(DATA_W), .DEPTH(LDQ_DEPTH), .MAX_POP(2)) u_ldq (
        .clk(clk), .rst_n(rst_n), .push(ld_push), .push_data(ld_in_data),
        .pop_n(ldq_pop_n), .head0(ldq_h0), .head1(ldq_h1),
        .count(ldq_cnt), .empty(ldq_empty), .full(ldq_full)
    );

    qmr_fifo #(.W(DATA_W), .DEPTH(STQ_DEPTH), .MAX_POP(1)) u_stq (
        .clk(clk), .rst_n(rst_n), .push(st_push), .push_data(wb_data),
        .pop_n({1'b0, st_pop}), .head0(stq_h0), .head1(stq_h1),
        .count(stq_cnt), .empty(stq_empty), .full(stq_full)
    );

    assign rf_addr[0] = iss_src_a;
    assign rf_addr[1] = iss_src_b;

    qmr_regfile #(.W(DATA_W), .NREGS(NUM_ARCH_REGS), .IDX_W(SPEC_W), .NRD(2)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wb_valid && !wb_to_q), .widx(wb_dst), .wdata(wb_data),
        .raddr(rf_addr), .rdata(rf_data)
    );

    always_comb begin
        unique case (sel_a)
            SRC_HEAD0: opnd_a = ldq_h0;
            SRC_HEAD1: opnd_a = ldq_h1;
            default:   opnd_a = rf_data[0];
        endcase
        unique case (sel_b)
            SRC_HEAD0: opnd_b = ldq_h0;
            SRC_HEAD1: opnd_b = ldq_h1;
            default:   opnd_b = rf_data[1];
        endcase
    end

    // R6: without an issue the load queue never shrinks
    a_r6_stall_keeps_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_ready) |=> (ldq_cnt >= $past(ldq_cnt)));

    // R5: a double queue source removes exactly two entries
    a_r5_two_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && sel_b == SRC_HEAD1)
        |=> ((ldq_cnt + LDQ_CW'(2)) == ($past(ldq_cnt) + LDQ_CW'($past(ld_push)))));

    // R8: a reserved store push always finds room
    a_r8_store_room: assert property (@(posedge clk) disable iff (!rst_n)
        st_push |-> !stq_full);

    // R10: a disabled queue source never selects queue data
    a_r10_disabled_src: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_src_a_en |-> (sel_a == SRC_REG));
endmodule

// File: tb/sim_qmr_operand_unit.sv
module sim_qmr_operand_unit;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_in_valid = 0, iss_valid = 0, iss_src_a_en = 0, iss_src_b_en = 0;
    logic        iss_dst_en = 0, wb_valid = 0, st_out_ready = 0;
    logic [4:0]  iss_src_a = 0, iss_src_b = 0, iss_dst = 0, wb_dst = 0;
    logic [31:0] ld_in_data = 0, wb_data = 0;
    logic        ld_in_ready, iss_ready, st_out_valid;
    logic [31:0] opnd_a, opnd_b, st_out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] rf_m [0:30];
    logic [31:0] ldq_m [$];
    logic [31:0] stq_m [$];
    int          resv_m = 0;

    always #2.5 clk = ~clk;

    qmr_operand_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_in_valid(ld_in_valid), .ld_in_ready(ld_in_ready), .ld_in_data(ld_in_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_src_a(iss_src_a), .iss_src_a_en(iss_src_a_en),
        .iss_src_b(iss_src_b), .iss_src_b_en(iss_src_b_en),
        .iss_dst(iss_dst), .iss_dst_en(iss_dst_en),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
        .st_out_valid(st_out_valid), .st_out_ready(st_out_ready), .st_out_data(st_out_data)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] src_val(input logic [4:0] code, input int qi,
                                            input bit wv, input logic [4:0] wd, input logic [31:0] wdat);
        if (code == 5'd31)            return ldq_m[qi];
        else if (wv && wd == code)    return wdat;
        else                          return rf_m[code];
    endfunction

    task automatic step(input string tag, input bit iv,
                        input logic [4:0] sa, input bit ae, input logic [4:0] sb, input bit be,
                        input logic [4:0] dd, input bit de,
                        input bit wv, input logic [4:0] wd, input logic [31:0] wdat,
                        input bit lv, input logic [31:0] ldat, input bit sr);
        int  ldn, stn, need;
        bit  exp_rdy, a_q, b_q, ld_acc, st_pop, resv_inc;
        @(negedge clk);
        iss_valid = iss_valid_f(iv);
        iss_src_a = sa; iss_src_a_en = ae; iss_src_b = sb; iss_src_b_en = be;
        iss_dst = dd; iss_dst_en = de;
        wb_valid = wv; wb_dst = wd; wb_data = wdat;
        ld_in_valid = lv; ld_in_data = ldat; st_out_ready = sr;
        #1;
        ldn  = ldq_m.size();
        stn  = stq_m.size();
        a_q  = ae && sa == 5'd31;
        b_q  = be && sb == 5'd31;
        need = int'(a_q) + int'(b_q);
        exp_rdy = (need <= ldn) && !(de && dd == 5'd31 && (stn + resv_m) >= 8);
        chk(tag, "iss_ready", {31'd0, iss_ready}, {31'd0, exp_rdy});
        chk(tag, "ld_in_ready", {31'd0, ld_in_ready}, {31'd0, ldn < 8});
        chk(tag, "st_out_valid", {31'd0, st_out_valid}, {31'd0, stn > 0});
        if (stn > 0) chk(tag, "st_out_data", st_out_data, stq_m[0]);
        if (iv && exp_rdy) begin
            if (ae) chk(tag, "opnd_a", opnd_a, src_val(sa, 0, wv, wd, wdat));
            if (be) chk(tag, "opnd_b", opnd_b, src_val(sb, a_q ? 1 : 0, wv, wd, wdat));
        end
        ld_acc   = lv && ldn < 8;
        st_pop   = sr && stn > 0;
        resv_inc = 0;
        if (iv && exp_rdy) begin
            for (int k = 0; k < need; k++) void'(ldq_m.pop_front());
            if (de && dd == 5'd31) resv_inc = 1;
        end
        if (st_pop) void'(stq_m.pop_front());
        if (wv) begin
            if (wd == 5'd31) begin
                if (resv_m > 0) begin
                    stq_m.push_back(wdat);
                    resv_m--;
                end
            end else begin
                rf_m[wd] = wdat;
            end
        end
        if (resv_inc) resv_m++;
        if (ld_acc) ldq_m.push_back(ldat);
    endtask

    function automatic logic iss_valid_f(input bit v);
        return v;
    endfunction

    task automatic nop(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic load(input string tag, input logic [31:0] v);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v, 0);
    endtask

    function automatic logic [4:0] pick_spec();
        if ($urandom % 4 == 0) return 5'd31;
        return 5'($urandom % 31);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 31; i++) rf_m[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step("R1", 1, 5, 1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: write then read
        step("R2", 0, 0, 0, 0, 0, 0, 0, 1, 5, 32'h1111_0005, 0, 0, 0);
        step("R2", 1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: same-cycle bypass on both ports
        step("R3", 1, 9, 1, 9, 1, 0, 0, 1, 9, 32'h9999_0009, 0, 0, 0);
        step("R3", 1, 9, 1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4: single queue source, arrival order
        load("R4", 32'hA000_0001);
        load("R4", 32'hA000_0002);
        load("R4", 32'hA000_0003);
        load("R4", 32'hA000_0004);
        step("R4", 1, 31, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 31, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10: disabled code-31 sources pop nothing
        step("R10", 1, 31, 0, 31, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10", 1, 31, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: one entry cannot serve two queue sources
        step("R6", 1, 31, 1, 31, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 31, 1, 31, 1, 0, 0, 0, 0, 0, 1, 32'hA000_0005, 0);
        // R5: double pop, A takes the older entry
        step("R5", 1, 31, 1, 31, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: fill load queue to its depth
        for (int i = 0; i < 9; i++) load("R9", 32'hB000_0000 + 32'(i));
        nop("R9");
        for (int i = 0; i < 4; i++) step("R5", 1, 31, 1, 31, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 31, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R7: reserve every store slot, the ninth issue waits
        for (int i = 0; i < 9; i++) step("R7", 1, 1, 0, 2, 0, 31, 1, 0, 0, 0, 0, 0, 0);
        // R8: fill reserved slots then drain in order
        for (int i = 0; i < 8; i++) step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 31, 32'hC000_0000 + 32'(i), 0, 0, 0);
        step("R7", 1, 1, 0, 2, 0, 31, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R8: an unreserved queue write is dropped
        step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 31, 32'hDEAD_0001, 0, 0, 1);
        nop("R8");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            bit          iv, ae, be, de, wv, lv, sr;
            logic [4:0]  sa, sb, dd, wd;
            iv = ($urandom % 10) < 7;
            sa = pick_spec(); sb = pick_spec(); dd = pick_spec();
            ae = ($urandom % 4) != 0; be = ($urandom % 4) != 0; de = ($urandom % 2) != 0;
            wv = ($urandom % 2) != 0;
            wd = 5'($urandom % 31);
            if (resv_m > 0 && ($urandom % 2) != 0) wd = 5'd31;
            lv = ($urandom % 2) != 0;
            sr = ($urandom % 3) != 0;
            step("R2/R6", iv, sa, ae, sb, be, dd, de, wv, wd, $urandom, lv, $urandom, sr);
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule